// File: doc/BRIEF.md
# Injection Beam Destination Arbiter

This block decides, once per supercycle, where the fill beam of the injector complex goes. At each supercycle-start strobe it looks at several inputs and latches one destination code. The inputs are the interlock fault, the user request, the mastership held by the filling sequencer, any pending beam request, the transfer-line inhibit, the operator's dump requests and the dump-in-place status. It also latches a beam-kill flag and the number of batches to deliver. All three outputs hold until the next strobe.

The sequencer gains or gives up mastership through a one-cycle command. The command is acknowledged only when the user request is absent and the change-allowed status is set; otherwise an error pulse is returned. While the sequencer is master it may load a beam request. The request names a ring, an RF bucket and a batch count. It is executed at the next supercycle that permits it and is then cleared.

Top module: `beam_dest_arbiter`

## Requirements
- R1: After reset, `dest` is SPARE (0), `kill` is 0, `batch_cnt` is 0, `own_ack` and `own_err` are 0, the sequencer is not master and no beam request is pending.
- R2: `dest`, `kill` and `batch_cnt` change only in the cycle after a cycle where `sc_start` is high, and hold their values in every other cycle.
- R3: When `intlk_fault` is high at a strobe, the outputs become SPARE (0) with `kill` 0 and `batch_cnt` 0, whatever the other inputs are. A pending request is kept.
- R4: When `user_req` is low at a strobe and no fault is present, the outputs become SPARE (0) with `kill` 0 and `batch_cnt` 0.
- R5: When the sequencer is master, a request is pending and `line_inhibit` is low at a strobe, `dest` becomes LINE1 (4) for ring bit 0 or LINE2 (5) for ring bit 1. `batch_cnt` becomes the request's batch count, and the request is then cleared.
- R6: When the sequencer is master and has no pending request, or `line_inhibit` is high, a strobe gives KILL (6) with `kill` 1 and `batch_cnt` 0. Dump requests have no effect in this case, and an inhibited request stays pending.
- R7: When the sequencer is not master, `dest` follows these rules, with `batch_cnt` set to `oper_batches` in each case:
  - LINE1_DUMP (2) if `l1_dump_req` and `dumps_in` are both high.
  - Otherwise LINE2_DUMP (3) if `l2_dump_req` and `dumps_in` are both high.
  - Otherwise INJ_DUMP (1).
  - A dump request has no effect while `dumps_in` is low.
- R8: An `own_cmd` pulse is answered one cycle later:
  - With `own_err` if `user_req` or not `own_allowed`; mastership is left unchanged.
  - Otherwise with `own_ack`, and mastership takes the value of `own_want`.
  - Without a command, mastership does not change and neither pulse is raised.
- R9: A `bq_load` is accepted only when all of these hold: the sequencer is master, `bq_batches` is 1 to 4, and `bq_bucket` is below 35640. An accepted load replaces any pending request; a load that is not accepted leaves the pending request as it was. Giving up mastership clears the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sc_start | input | 1 | Supercycle-start strobe |
| intlk_fault | input | 1 | Abnormal interlock present |
| user_req | input | 1 | User request for the fill beam |
| own_cmd | input | 1 | Mastership change command pulse |
| own_want | input | 1 | Requested mastership (1 take, 0 release) |
| own_allowed | input | 1 | Change-allowed status bit |
| bq_load | input | 1 | Load a beam request |
| bq_ring | input | 1 | Ring of the request (0 ring 1, 1 ring 2) |
| bq_bucket | input | 16 | RF bucket of the request |
| bq_batches | input | 3 | Batch count of the request |
| line_inhibit | input | 1 | Transfer-line inhibit |
| l1_dump_req | input | 1 | Line 1 dump requested |
| l2_dump_req | input | 1 | Line 2 dump requested |
| dumps_in | input | 1 | Transfer-line dumps in place |
| oper_batches | input | 3 | Batch count chosen by the operator when not master |
| dest | output | 3 | Destination code |
| kill | output | 1 | Beam killed at the source |
| batch_cnt | output | 3 | Batches to deliver |
| own_ack | output | 1 | Mastership change accepted |
| own_err | output | 1 | Mastership change refused |

## Verification
The assertions take for granted that every input is synchronous to `clk` and known from the first edge after reset. They also take for granted that `sc_start`, `own_cmd` and `bq_load` are sampled as single-cycle levels, with no meaning carried across edges. The bench changes its inputs only on the falling clock edge, so every input is settled before the rising edge.

The bench holds `rst_n` low from time zero, so no property sees an unknown value. A directed phase drives the strobes as one-cycle pulses. A random phase may repeat a strobe on consecutive cycles, and each of those cycles then counts as its own decision.

// File: rtl/beam_dest_pkg.sv
// Shared destination encoding for the injection beam arbiter.
package beam_dest_pkg;
    localparam int DEST_W = 3;

    typedef enum logic [DEST_W-1:0] {
        D_SPARE    = 3'd0,
        D_INJ_DUMP = 3'd1,
        D_L1_DUMP  = 3'd2,
        D_L2_DUMP  = 3'd3,
        D_LINE1    = 3'd4,
        D_LINE2    = 3'd5,
        D_KILL     = 3'd6
    } dest_e;
endpackage

// File: rtl/own_ctrl.sv
// Mastership state of the filling sequencer.
// Evaluates a one-cycle change command against the user request and the
// change-allowed bit, and answers with a registered ack or error pulse.
// Assumes all inputs are synchronous to clk.
module own_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic want,
    input  logic allowed,
    input  logic user_req,
    output logic master,
    output logic ack,
    output logic err
);
    // Update mastership and produce the one-cycle answer pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master <= 1'b0;
            ack    <= 1'b0;
            err    <= 1'b0;
        end else begin
            ack <= 1'b0;
            err <= 1'b0;
            if (cmd) begin
                if (user_req || !allowed) begin
                    err <= 1'b1;
                end else begin
                    ack    <= 1'b1;
                    master <= want;
                end
            end
        end
    end

    // R8
    refuse_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd && user_req |=> err && !ack);
    // R8
    quiet_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd |=> !ack && !err);
    // R8
    master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd |=> $stable(master));
endmodule

// File: rtl/beam_req_latch.sv
// Holds the pending beam request of the sequencer.
// A load is taken only while master and with a valid bucket and batch
// count. The request is cleared when it is consumed or when mastership
// is lost. Assumes consume is high only in a strobe cycle that uses it.
module beam_req_latch #(
    parameter int BKT_W     = 16,
    parameter int BUCKETS   = 35640,
    parameter int BATCH_W   = 3,
    parameter int MAX_BATCH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               master,
    input  logic               ring,
    input  logic [BKT_W-1:0]   bucket,
    input  logic [BATCH_W-1:0] batches,
    input  logic               consume,
    output logic               pend_v,
    output logic               pend_ring,
    output logic [BATCH_W-1:0] pend_bat
);
    localparam logic [BKT_W-1:0]   BKT_LIM = BKT_W'(BUCKETS);
    localparam logic [BATCH_W-1:0] BAT_LIM = BATCH_W'(MAX_BATCH);

    logic load_ok;

    // Decide whether the offered request is acceptable.
    always_comb begin
        load_ok = load && master && (batches != '0) &&
                  (batches <= BAT_LIM) && (bucket < BKT_LIM);
    end

    // Store, replace or clear the pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_ring <= 1'b0;
            pend_bat  <= '0;
        end else if (load_ok) begin
            pend_v    <= 1'b1;
            pend_ring <= ring;
            pend_bat  <= batches;
        end else if (consume || !master) begin
            pend_v    <= 1'b0;
        end
    end

    // R9
    no_master_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && !master |=> !pend_v);
    // R9
    zero_batch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load && master && batches == '0 && !consume |=> $stable(pend_v));
endmodule

// File: rtl/dest_select.sv
// Combinational priority rules for the beam destination.
// Priority: interlock, absent user request, master rules, dump requests,
// then the default. Assumes the caller registers the result at a strobe.
module dest_select
    import beam_dest_pkg::*;
#(
    parameter int BATCH_W = 3
) (
    input  logic               fault,
    input  logic               user_req,
    input  logic               master,
    input  logic               pend_v,
    input  logic               pend_ring,
    input  logic [BATCH_W-1:0] pend_bat,
    input  logic               inhibit,
    input  logic               l1_req,
    input  logic               l2_req,
    input  logic               in_place,
    input  logic [BATCH_W-1:0] oper_bat,
    output dest_e              dest,
    output logic               kill,
    output logic [BATCH_W-1:0] bat,
    output logic               use_req
);
    // Pick the destination by fixed priority.
    always_comb begin
        dest    = D_SPARE;
        kill    = 1'b0;
        bat     = '0;
        use_req = 1'b0;
        if (fault || !user_req) begin
            dest = D_SPARE;
        end else if (master) begin
            if (pend_v && !inhibit) begin
                dest    = pend_ring ? D_LINE2 : D_LINE1;
                bat     = pend_bat;
                use_req = 1'b1;
            end else begin
                dest = D_KILL;
                kill = 1'b1;
            end
        end else if (l1_req && in_place) begin
            dest = D_L1_DUMP;
            bat  = oper_bat;
        end else if (l2_req && in_place) begin
            dest = D_L2_DUMP;
            bat  = oper_bat;
        end else begin
            dest = D_INJ_DUMP;
            bat  = oper_bat;
        end
    end
endmodule

// File: rtl/beam_dest_arbiter.sv
// Injection beam destination arbiter (top).
// Latches the destination, kill flag and batch count once per supercycle
// strobe and holds them until the next strobe. Assumes all inputs are
// synchronous to clk and sampled as single-cycle levels.
module beam_dest_arbiter
    import beam_dest_pkg::*;
#(
    parameter int BKT_W     = 16,
    parameter int BUCKETS   = 35640,
    parameter int BATCH_W   = 3,
    parameter int MAX_BATCH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sc_start,
    input  logic               intlk_fault,
    input  logic               user_req,
    input  logic               own_cmd,
    input  logic               own_want,
    input  logic               own_allowed,
    input  logic               bq_load,
    input  logic               bq_ring,
    input  logic [BKT_W-1:0]   bq_bucket,
    input  logic [BATCH_W-1:0] bq_batches,
    input  logic               line_inhibit,
    input  logic               l1_dump_req,
    input  logic               l2_dump_req,
    input  logic               dumps_in,
    input  logic [BATCH_W-1:0] oper_batches,
    output logic [DEST_W-1:0]  dest,
    output logic               kill,
    output logic [BATCH_W-1:0] batch_cnt,
    output logic               own_ack,
    output logic               own_err
);
    logic               master;
    logic               pend_v;
    logic               pend_ring;
    logic [BATCH_W-1:0] pend_bat;
    dest_e              sel_dest;
    logic               sel_kill;
    logic [BATCH_W-1:0] sel_bat;
    logic               sel_use;
    logic               consume;
    dest_e              dest_q;

    own_ctrl u_own (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (own_cmd),
        .want     (own_want),
        .allowed  (own_allowed),
        .user_req (user_req),
        .master   (master),
        .ack      (own_ack),
        .err      (own_err)
    );

    beam_req_latch #(
        .BKT_W     (BKT_W),
        .BUCKETS   (BUCKETS),
        .BATCH_W   (BATCH_W),
        .MAX_BATCH (MAX_BATCH)
    ) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (bq_load),
        .master    (master),
        .ring      (bq_ring),
        .bucket    (bq_bucket),
        .batches   (bq_batches),
        .consume   (consume),
        .pend_v    (pend_v),
        .pend_ring (pend_ring),
        .pend_bat  (pend_bat)
    );

    dest_select #(.BATCH_W(BATCH_W)) u_sel (
        .fault     (intlk_fault),
        .user_req  (user_req),
        .master    (master),
        .pend_v    (pend_v),
        .pend_ring (pend_ring),
        .pend_bat  (pend_bat),
        .inhibit   (line_inhibit),
        .l1_req    (l1_dump_req),
        .l2_req    (l2_dump_req),
        .in_place  (dumps_in),
        .oper_bat  (oper_batches),
        .dest      (sel_dest),
        .kill      (sel_kill),
        .bat       (sel_bat),
        .use_req   (sel_use)
    );

    // A request is consumed only when a strobe actually sends it.
    always_comb begin
        consume = sc_start && sel_use;
    end

    // Latch the decision at the supercycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q    <= D_SPARE;
            kill      <= 1'b0;
            batch_cnt <= '0;
        end else if (sc_start) begin
            dest_q    <= sel_dest;
            kill      <= sel_kill;
            batch_cnt <= sel_bat;
        end
    end

    assign dest = dest_q;

    // R2
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_start |=> $stable(dest) && $stable(kill) && $stable(batch_cnt));
    // R3
    fault_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_start && intlk_fault |=> dest == D_SPARE && !kill && batch_cnt == '0);
    // R6
    kill_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> dest == D_KILL);
    // R7
    dump_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_start && !dumps_in |=> dest != D_L1_DUMP && dest != D_L2_DUMP);
endmodule

// File: tb/beam_dest_arbiter_tb.sv
module beam_dest_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sc_start = 1'b0, intlk_fault = 1'b0, user_req = 1'b0;
    logic       own_cmd = 1'b0, own_want = 1'b0, own_allowed = 1'b0;
    logic       bq_load = 1'b0, bq_ring = 1'b0;
    logic [15:0] bq_bucket = '0;
    logic [2:0] bq_batches = '0;
    logic       line_inhibit = 1'b0, l1_dump_req = 1'b0, l2_dump_req = 1'b0, dumps_in = 1'b0;
    logic [2:0] oper_batches = '0;
    logic [2:0] dest;
    logic       kill;
    logic [2:0] batch_cnt;
    logic       own_ack, own_err;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit model_live = 0;
    bit done = 0;

    // Reference model state
    bit     m_master, m_pv, m_pring;
    int     m_pbat;
    int     e_dest, e_bat;
    bit     e_kill, e_ack, e_err;
    string  e_tag = "R1";

    always #10 clk = ~clk;

    beam_dest_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .sc_start(sc_start), .intlk_fault(intlk_fault),
        .user_req(user_req), .own_cmd(own_cmd), .own_want(own_want),
        .own_allowed(own_allowed), .bq_load(bq_load), .bq_ring(bq_ring),
        .bq_bucket(bq_bucket), .bq_batches(bq_batches), .line_inhibit(line_inhibit),
        .l1_dump_req(l1_dump_req), .l2_dump_req(l2_dump_req), .dumps_in(dumps_in),
        .oper_batches(oper_batches), .dest(dest), .kill(kill), .batch_cnt(batch_cnt),
        .own_ack(own_ack), .own_err(own_err)
    );

    // Behavioural reference: evaluates the rules at every rising edge.
    always @(posedge clk) begin
        bit used;
        bit ok;
        used = 0;
        model_live = 1;
        if (!rst_n) begin
            m_master = 0; m_pv = 0; m_pring = 0; m_pbat = 0;
            e_dest = 0; e_bat = 0; e_kill = 0; e_ack = 0; e_err = 0;
            e_tag = "R1";
        end else begin
            if (sc_start) begin
                e_kill = 0; e_bat = 0;
                if (intlk_fault) begin e_dest = 0; e_tag = "R3"; end
                else if (!user_req) begin e_dest = 0; e_tag = "R4"; end
                else if (m_master) begin
                    if (m_pv && !line_inhibit) begin
                        e_dest = m_pring ? 5 : 4; e_bat = m_pbat; used = 1; e_tag = "R5";
                    end else begin
                        e_dest = 6; e_kill = 1; e_tag = "R6";
                    end
                end else begin
                    e_tag = "R7"; e_bat = oper_batches;
                    if (l1_dump_req && dumps_in) e_dest = 2;
                    else if (l2_dump_req && dumps_in) e_dest = 3;
                    else e_dest = 1;
                end
            end else if (e_tag.len() == 2) begin
                e_tag = {"R2 hold after ", e_tag};
            end
            // request storage (R9), using mastership before this edge
            ok = bq_load && m_master && bq_batches >= 1 && bq_batches <= 4 && bq_bucket < 35640;
            if (ok) begin m_pv = 1; m_pring = bq_ring; m_pbat = bq_batches; end
            else if (used || !m_master) m_pv = 0;
            // mastership (R8)
            e_ack = 0; e_err = 0;
            if (own_cmd) begin
                if (user_req || !own_allowed) e_err = 1;
                else begin e_ack = 1; m_master = own_want; end
            end
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (model_live && !done) begin
            cycles++;
            compared++;
            if (dest !== 3'(e_dest) || kill !== e_kill || batch_cnt !== 3'(e_bat)) begin
                mismatched++;
                $display("FAIL %s: dest/kill/batch got %0d/%0d/%0d exp %0d/%0d/%0d at %0t",
                         e_tag, dest, kill, batch_cnt, e_dest, e_kill, e_bat, $time);
            end
            compared++;
            if (own_ack !== e_ack || own_err !== e_err) begin
                mismatched++;
                $display("FAIL %s: ack/err got %0d/%0d exp %0d/%0d at %0t",
                         rst_n ? "R8" : "R1", own_ack, own_err, e_ack, e_err, $time);
            end
            if (cycles > 100000) begin
                mismatched++;
                $display("FAIL watchdog expired");
                done = 1;
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sc_start = 0; own_cmd = 0; bq_load = 0;
        end
    endtask

    task automatic strobe();
        sc_start = 1; tick(2);
    endtask

    task automatic mcmd(bit want);
        own_cmd = 1; own_want = want; tick(2);
    endtask

    task automatic load(bit ring, int bucket, int bat);
        bq_load = 1; bq_ring = ring; bq_bucket = 16'(bucket); bq_batches = 3'(bat); tick(1);
    endtask

    initial begin
        tick(3);                                  // R1 reset state
        rst_n = 1; tick(2);
        strobe();                                 // R4 no user request
        user_req = 1; oper_batches = 3; strobe(); // R7 default injector dump
        l1_dump_req = 1; strobe();                // R7 ignored without dumps in place
        dumps_in = 1; strobe();                   // R7 line 1 dump
        l2_dump_req = 1; strobe();                // R7 line 1 has priority
        l1_dump_req = 0; strobe();                // R7 line 2 dump
        intlk_fault = 1; strobe();                // R3 fault overrides
        intlk_fault = 0;
        load(0, 100, 2); strobe();                // R9 load refused when not master
        mcmd(1);                                  // R8 refused: user present
        user_req = 0; mcmd(1);                    // R8 refused: not allowed
        own_allowed = 1; mcmd(1);                 // R8 accepted
        user_req = 1; strobe();                   // R6 kill, dump requests ignored
        load(0, 10, 0); load(0, 10, 5); load(1, 35640, 2); strobe(); // R9 invalid loads
        load(1, 35639, 4); tick(2); strobe();     // R5 ring 2, 4 batches
        strobe();                                 // R5 request cleared, back to kill
        load(0, 0, 1); line_inhibit = 1; strobe(); // R6 inhibited keeps request
        line_inhibit = 0; strobe();               // R5 line 1
        load(0, 5, 3); load(1, 6, 2); intlk_fault = 1; strobe(); // R9 replace, R3 keeps
        intlk_fault = 0; strobe();                // R5 line 2 from replaced request
        load(0, 7, 1); user_req = 0; mcmd(0);     // R8 release, R9 clears pending
        user_req = 1; strobe();                   // R7 not master again
        // random phase
        for (int i = 0; i < 3000; i++) begin
            sc_start     = ($urandom % 5) == 0;
            intlk_fault  = ($urandom % 10) == 0;
            user_req     = ($urandom % 4) != 0;
            own_cmd      = ($urandom % 12) == 0;
            own_want     = ($urandom % 3) != 0;
            own_allowed  = ($urandom % 3) != 0;
            bq_load      = ($urandom % 5) == 0;
            bq_ring      = 1'($urandom);
            bq_bucket    = 16'($urandom % 40000);
            bq_batches   = 3'($urandom % 6);
            line_inhibit = ($urandom % 4) == 0;
            l1_dump_req  = 1'($urandom);
            l2_dump_req  = 1'($urandom);
            dumps_in     = 1'($urandom);
            oper_batches = 3'($urandom % 5);
            @(negedge clk);
        end
        tick(2);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule